// File: doc/BRIEF.md
# Banked Special-Register Port with TLB Update Side Effects

This block sits beside a processor core and serves its moves to and from special registers. The core presents a bank-select value, a register number and either a write strobe with data or a read strobe. There are four banks of sixteen 32-bit special registers. Banks 1 and 2 are MMU banks: each one owns a software-managed TLB of 4 sets by 16 entries, and each entry holds a hi word and a lo word.

In an MMU bank, some register accesses also act on the TLB. Writing the TLB-hi register also loads the cause register. Writing the TLB-lo register commits a whole entry. The entry's lo word is the written data and its hi word is the current cause value. The same write sends a one-cycle request to invalidate the page that the entry mapped before. Any read in an MMU bank first refreshes the TLB-hi and TLB-lo mirror registers from the selected entry, and then returns the requested register. Banks 0 and 3 are plain storage.

Top module: `mmu_sreg_port`

## Requirements
- R1: A synchronous reset clears every special register and every TLB word to zero and drops `rd_valid` and `flush_req`; a read after reset returns zero.
- R2: Only bits [1:0] of `bank_sel` choose the bank, so bank_sel values 1 and 5 reach the same registers.
- R3: In banks 0 and 3, a write only stores the data into the addressed register. It raises no flush and changes no other register, and this includes register numbers 5 and 6.
- R4: In an MMU bank (1 or 2), writing register 6 (TLB-hi) stores the data in register 6 and also in register 7 (cause) of the same bank.
- R5: In an MMU bank, writing register 5 (TLB-lo) stores the data in register 5 and commits one TLB entry with lo word = data and hi word = that bank's register 7 as it was before the write. The entry is chosen by register 4 of the bank: bits [5:4] give the set and bits [3:0] give the index.
- R6: Each such TLB-lo write raises `flush_req` for exactly the cycle after the write edge. `flush_addr` is the old hi word with bits [12:0] cleared, and `flush_old_valid` is bit 3 of the old lo word.
- R7: A read in an MMU bank loads register 5 with the selected entry's lo word and register 6 with its hi word, on the same edge. The returned data reflects this refresh.
- R8: `rd_data` and `rd_valid` are registered and appear one cycle after `rd_en`. A read strobe that comes together with a write strobe is ignored.
- R9: Bank 1 uses TLB array 0 and bank 2 uses TLB array 1. An entry committed through one bank is not visible through the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bank_sel | input | SEL_W | Bank-select value; only the low 2 bits are used |
| reg_num | input | 4 | Special register number |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | High for one cycle when rd_data is valid |
| flush_req | output | 1 | One-cycle page-invalidate request |
| flush_addr | output | 32 | Page-aligned address of the displaced page |
| flush_old_valid | output | 1 | Valid bit of the displaced entry |

## Verification
The assertions check the timing relations on every cycle. A flush pulse only ever follows a TLB-lo write in an MMU bank. A write in a plain bank never produces one. Read data is valid exactly one cycle after a read that came without a write. The values themselves can only be shown through the bench's scenarios and the reference model. These are the cause copy, the entry contents, the flush address of the displaced page, the mirror refresh seen in read data, and the separation of the two TLB arrays.

// File: rtl/mmu_sreg_port.sv
module mmu_sreg_port #(
  parameter int SEL_W     = 8,
  parameter int PAGE_BITS = 13,
  parameter int SEL_REG   = 4,
  parameter int LO_REG    = 5,
  parameter int HI_REG    = 6,
  parameter int CAUSE_REG = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] bank_sel,
  input  logic [3:0]       reg_num,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  input  logic             rd_en,
  output logic [31:0]      rd_data,
  output logic             rd_valid,
  output logic             flush_req,
  output logic [31:0]      flush_addr,
  output logic             flush_old_valid
);
  localparam int NREG    = 16;
  localparam int NBANK   = 4;
  localparam int NENT    = 64;
  localparam logic [31:0] PAGE_MASK = ~((32'd1 << PAGE_BITS) - 32'd1);

  logic [31:0] sreg   [NBANK][NREG];
  logic [31:0] tlb_hi [2][NENT];
  logic [31:0] tlb_lo [2][NENT];

  logic [1:0]  bank;
  logic        mmu;
  logic        tsel;
  logic [5:0]  ent;
  logic [31:0] old_hi, old_lo;

  assign bank   = bank_sel[1:0];
  assign mmu    = (bank == 2'd1) || (bank == 2'd2);
  assign tsel   = (bank == 2'd2);
  assign ent    = sreg[bank][SEL_REG][5:0];
  assign old_hi = tlb_hi[tsel][ent];
  assign old_lo = tlb_lo[tsel][ent];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NBANK; b++)
        for (int r = 0; r < NREG; r++) sreg[b][r] <= '0;
      for (int t = 0; t < 2; t++)
        for (int e = 0; e < NENT; e++) begin
          tlb_hi[t][e] <= '0;
          tlb_lo[t][e] <= '0;
        end
      rd_data         <= '0;
      rd_valid        <= 1'b0;
      flush_req       <= 1'b0;
      flush_addr      <= '0;
      flush_old_valid <= 1'b0;
    end else begin
      rd_valid  <= 1'b0;
      flush_req <= 1'b0;
      if (wr_en) begin
        sreg[bank][reg_num] <= wr_data;
        if (mmu && reg_num == 4'(HI_REG))
          sreg[bank][CAUSE_REG] <= wr_data;
        if (mmu && reg_num == 4'(LO_REG)) begin
          tlb_lo[tsel][ent] <= wr_data;
          tlb_hi[tsel][ent] <= sreg[bank][CAUSE_REG];
          flush_req         <= 1'b1;
          flush_addr        <= old_hi & PAGE_MASK;
          flush_old_valid   <= old_lo[3];
        end
      end else if (rd_en) begin
        rd_valid <= 1'b1;
        if (mmu) begin
          sreg[bank][LO_REG] <= old_lo;
          sreg[bank][HI_REG] <= old_hi;
        end
        if (mmu && reg_num == 4'(LO_REG))      rd_data <= old_lo;
        else if (mmu && reg_num == 4'(HI_REG)) rd_data <= old_hi;
        else                                   rd_data <= sreg[bank][reg_num];
      end
    end
  end

  assert_flush_source_R6: assert property (@(posedge clk) disable iff (rst)
    flush_req |-> $past(!rst && wr_en && mmu && reg_num == 4'(LO_REG)));

  assert_plain_no_flush_R3: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && wr_en && !mmu) |-> !flush_req);

  assert_rd_valid_source_R8: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(!rst && rd_en && !wr_en));

  assert_rd_latency_R8: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && rd_en && !wr_en) |-> rd_valid);

  assert_write_blocks_read_R8: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && wr_en) |-> !rd_valid);
endmodule

// File: tb/mmu_sreg_port_tb_top.sv
module mmu_sreg_port_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bank_sel = '0;
  logic [3:0]  reg_num = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        rd_valid, flush_req, flush_old_valid;
  logic [31:0] flush_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mmu_sreg_port dut_i (
    .clk(clk), .rst(rst), .bank_sel(bank_sel), .reg_num(reg_num),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .rd_valid(rd_valid), .flush_req(flush_req),
    .flush_addr(flush_addr), .flush_old_valid(flush_old_valid)
  );

  // behavioural reference model
  logic [31:0] m_sreg [4][16];
  logic [31:0] m_hi [2][64];
  logic [31:0] m_lo [2][64];
  logic [31:0] m_rd, m_fa;
  logic        m_valid, m_flush, m_fv;

  always @(posedge clk) begin
    int b, t, e;
    bit mmu;
    m_valid = 0;
    m_flush = 0;
    if (rst) begin
      foreach (m_sreg[i, j]) m_sreg[i][j] = '0;
      foreach (m_hi[i, j]) begin m_hi[i][j] = '0; m_lo[i][j] = '0; end
    end else begin
      b = int'(bank_sel % 4);
      mmu = (b == 1 || b == 2);
      t = b - 1;
      if (t < 0) t = 0;
      e = int'(m_sreg[b][4] % 64);
      if (wr_en) begin
        if (mmu && reg_num == 5) begin
          m_fa = m_hi[t][e] & 32'hFFFF_E000;
          m_fv = m_lo[t][e][3];
          m_hi[t][e] = m_sreg[b][7];
          m_lo[t][e] = wr_data;
          m_flush = 1;
        end
        m_sreg[b][reg_num] = wr_data;
        if (mmu && reg_num == 6) m_sreg[b][7] = wr_data;
      end else if (rd_en) begin
        if (mmu) begin
          m_sreg[b][5] = m_lo[t][e];
          m_sreg[b][6] = m_hi[t][e];
        end
        m_rd = m_sreg[b][reg_num];
        m_valid = 1;
      end
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check({31'd0, rd_valid}, {31'd0, m_valid}, "R8 rd_valid vs model");
      if (m_valid) check(rd_data, m_rd, "R7 rd_data vs model");
      check({31'd0, flush_req}, {31'd0, m_flush}, "R6 flush_req vs model");
      if (m_flush) begin
        check(flush_addr, m_fa, "R6 flush_addr vs model");
        check({31'd0, flush_old_valid}, {31'd0, m_fv}, "R6 flush_old_valid vs model");
      end
    end
  end

  task automatic idle();
    wr_en = 0; rd_en = 0;
  endtask

  task automatic wr(input logic [7:0] b, input logic [3:0] r, input logic [31:0] d);
    @(negedge clk);
    bank_sel = b; reg_num = r; wr_data = d; wr_en = 1; rd_en = 0;
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input logic [7:0] b, input logic [3:0] r, input logic [31:0] exp, input string req);
    @(negedge clk);
    bank_sel = b; reg_num = r; rd_en = 1; wr_en = 0;
    @(negedge clk);
    idle();
    check({31'd0, rd_valid}, 32'd1, req);
    check(rd_data, exp, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check({30'd0, rd_valid, flush_req}, 32'd0, "R1 outputs after reset");
    rst = 0;
    rd(8'd1, 4'd7, 32'd0, "R1 cleared after reset");
    rd(8'd3, 4'd2, 32'd0, "R1 cleared after reset");

    // R4: hi write copies to cause
    wr(8'd1, 4'd6, 32'hABCD_E123);
    rd(8'd1, 4'd7, 32'hABCD_E123, "R4 cause copy");
    // R5/R6: commit entry set2 idx5
    wr(8'd1, 4'd4, 32'h0000_0025);
    @(negedge clk);
    bank_sel = 8'd1; reg_num = 4'd5; wr_data = 32'h0000_0008; wr_en = 1;
    @(negedge clk);
    idle();
    check({31'd0, flush_req}, 32'd1, "R6 flush pulse");
    check(flush_addr, 32'd0, "R6 flush addr of empty entry");
    @(negedge clk);
    check({31'd0, flush_req}, 32'd0, "R6 flush one cycle");
    wr(8'd1, 4'd7, 32'h1111_2000);
    @(negedge clk);
    bank_sel = 8'd1; reg_num = 4'd5; wr_data = 32'h0; wr_en = 1;
    @(negedge clk);
    idle();
    check(flush_addr, 32'hABCD_E000, "R6 displaced page address");
    check({31'd0, flush_old_valid}, 32'd1, "R6 displaced valid bit");
    // R7: read refreshes mirrors from entry (hi=0x11112000 lo=0)
    rd(8'd1, 4'd6, 32'h1111_2000, "R7 mirror hi refresh");
    rd(8'd1, 4'd2, 32'd0, "R7 read other reg");
    // R2: bank_sel 5 aliases bank 1
    rd(8'd5, 4'd6, 32'h1111_2000, "R2 bank alias");
    // R9: bank 2 array separate
    wr(8'd2, 4'd4, 32'h0000_0025);
    rd(8'd2, 4'd6, 32'd0, "R9 separate array");
    // R3: plain bank has no side effects
    wr(8'd0, 4'd6, 32'h5555_0000);
    rd(8'd0, 4'd7, 32'd0, "R3 no cause copy in plain bank");
    @(negedge clk);
    bank_sel = 8'd3; reg_num = 4'd5; wr_data = 32'h77; wr_en = 1;
    @(negedge clk);
    idle();
    check({31'd0, flush_req}, 32'd0, "R3 no flush in plain bank");
    rd(8'd3, 4'd5, 32'h77, "R3 plain storage");
    rd(8'd0, 4'd6, 32'h5555_0000, "R3 plain read no refresh");
    // R8: read with write ignored
    @(negedge clk);
    bank_sel = 8'd0; reg_num = 4'd1; wr_data = 32'h9; wr_en = 1; rd_en = 1;
    @(negedge clk);
    idle();
    check({31'd0, rd_valid}, 32'd0, "R8 read ignored during write");

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      bank_sel = 8'($urandom);
      reg_num  = ($urandom % 2) ? 4'(4 + $urandom % 4) : 4'($urandom);
      wr_data  = $urandom;
      wr_en    = ($urandom % 3) == 0;
      rd_en    = ($urandom % 2) == 0;
    end
    @(negedge clk);
    idle();
    repeat (2) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule